// File: doc/BRIEF.md
# Addressed Packet Protocol Controller

This block sits above a byte-framing receiver on a shared serial line. Each time the framer finishes a packet it presents a one-cycle completion event with the payload length, the first payload byte and the first four payload bytes packed into a word. The controller works out from the length alone what kind of packet arrived. Using a small three-state machine, it then decides whether this node is being spoken to. It accepts an image that arrives as two equal halves, answers a discovery probe shortly after reset, and answers a status command.

Its outputs go to the neighbouring logic. These are the byte offset at which the framer must store the next packet, a one-cycle request to reformat the received image, one-cycle requests for a discovery reply and for a status reply, two saturating error counters, and three pulse-stretched indicator lamps. A millisecond tick is derived from the clock by a prescaler. The same tick times both the discovery window and the lamp hold time.

Top module: `pkt_proto_ctrl`

## Requirements
- R1: After reset the machine is in its ignore state, the write offset is 0, all request pulses and both counters are 0 and all three lamps are dark.
- R2: A zero-length packet raises `disc_req` for one cycle only while fewer than DISC_MS millisecond ticks have elapsed since reset; later it raises nothing. It leaves the machine state unchanged.
- R3: A 4-byte packet whose packed word equals `node_id` moves the machine to the addressed state; a 4-byte packet with any other word moves it to the ignore state.
- R4: A 1-byte packet in the addressed state raises `stat_req` for one cycle if its byte is 0x01, and does nothing else for any other byte. In any other state it adds one to `invalid_cnt` and triggers the error lamp. Either way the machine returns to ignore.
- R5: A packet of HALF_LEN bytes in the addressed state moves the machine to the second-half state and sets `wr_offset` to HALF_LEN. A HALF_LEN packet in the ignore state has no effect besides the communication lamp.
- R6: A HALF_LEN packet in the second-half state raises `fmt_req` for one cycle when `fb_idle` is 1, and triggers the identify lamp. When `fb_idle` is 0 it instead adds one to `overrun_cnt` and triggers the error lamp. The machine then returns to ignore.
- R7: A packet whose length is none of 0, 1, 4 and HALF_LEN adds one to `invalid_cnt`, triggers the error lamp and moves the machine to ignore.
- R8: `wr_offset` is 0 after every packet that does not leave the machine in the second-half state.
- R9: Every packet triggers the communication lamp. A triggered lamp stays lit until STRETCH_MS ticks have passed without a new trigger, so triggers spaced closer than that keep it lit continuously.
- R10: Both counters saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | One-cycle packet-complete event |
| pkt_len | input | LEN_W | Payload length of the completed packet |
| pkt_byte | input | 8 | First payload byte (command code) |
| pkt_word | input | 32 | First four payload bytes (address word) |
| node_id | input | 32 | This node's identifier |
| fb_idle | input | 1 | Image buffer free to accept a reformat |
| wr_offset | output | LEN_W | Byte offset for storing the next packet |
| fmt_req | output | 1 | Reformat request pulse |
| disc_req | output | 1 | Discovery reply request pulse |
| stat_req | output | 1 | Status reply request pulse |
| invalid_cnt | output | CNT_W | Saturating invalid-packet count |
| overrun_cnt | output | CNT_W | Saturating image-overrun count |
| led_comm | output | 1 | Communication lamp |
| led_err | output | 1 | Error lamp |
| led_id | output | 1 | Identify lamp |

## Verification
The bench probes the state-dependent meaning of each length. A one-byte packet outside the addressed state must count as an error and not request a status reply. A half-image packet in the ignore state must be silently dropped; a design that fell through to the error path would show a rising invalid count. The second half arriving while the buffer is busy must bump the overrun counter and raise no reformat, and the offset must drop back to zero once that half is consumed. Discovery is tried inside and well outside the post-reset window. The lamps are checked for continuous light under triggers closer together than the hold time, and for going dark after it. A run of bad packets past the counter's capacity exposes a counter that wraps.

// File: rtl/pkt_proto_ctrl.sv
module pkt_proto_ctrl #(
  parameter int LEN_W        = 16,
  parameter int HALF_LEN     = 320,
  parameter int CNT_W        = 16,
  parameter int TICKS_PER_MS = 50000,
  parameter int DISC_MS      = 100,
  parameter int STRETCH_MS   = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       pkt_byte,
  input  logic [31:0]      pkt_word,
  input  logic [31:0]      node_id,
  input  logic             fb_idle,
  output logic [LEN_W-1:0] wr_offset,
  output logic             fmt_req,
  output logic             disc_req,
  output logic             stat_req,
  output logic [CNT_W-1:0] invalid_cnt,
  output logic [CNT_W-1:0] overrun_cnt,
  output logic             led_comm,
  output logic             led_err,
  output logic             led_id
);
  localparam int PRE_W = $clog2(TICKS_PER_MS + 1);
  localparam int MS_W  = $clog2(DISC_MS + 1);
  localparam int LT_W  = $clog2(STRETCH_MS + 1);
  localparam logic [LEN_W-1:0] HALF = LEN_W'(HALF_LEN);
  localparam logic [7:0] CMD_STATUS = 8'h01;

  typedef enum logic [1:0] {S_ADDR = 2'd0, S_SECOND = 2'd1, S_IGN = 2'd2} st_t;

  st_t             st, st_nxt;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms_cnt;
  logic             ms_tick;
  logic             is_disc, is_cmd, is_adr, is_half;
  logic             hit_disc, hit_stat, hit_fmt, hit_ovr, hit_inv;

  assign ms_tick  = (pre == PRE_W'(TICKS_PER_MS - 1));
  assign is_disc  = (pkt_len == '0);
  assign is_cmd   = (pkt_len == LEN_W'(1));
  assign is_adr   = (pkt_len == LEN_W'(4));
  assign is_half  = (pkt_len == HALF) && !is_disc && !is_cmd && !is_adr;

  assign hit_disc = pkt_valid && is_disc && (ms_cnt < MS_W'(DISC_MS));
  assign hit_stat = pkt_valid && is_cmd && st == S_ADDR && pkt_byte == CMD_STATUS;
  assign hit_fmt  = pkt_valid && is_half && st == S_SECOND && fb_idle;
  assign hit_ovr  = pkt_valid && is_half && st == S_SECOND && !fb_idle;
  assign hit_inv  = pkt_valid && ((is_cmd && st != S_ADDR) ||
                                  !(is_disc || is_cmd || is_adr || is_half));

  always_comb begin
    st_nxt = st;
    if (pkt_valid) begin
      if (is_disc)      st_nxt = st;
      else if (is_adr)  st_nxt = (pkt_word == node_id) ? S_ADDR : S_IGN;
      else if (is_half) st_nxt = (st == S_ADDR) ? S_SECOND : S_IGN;
      else              st_nxt = S_IGN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IGN;
      pre       <= '0;
      ms_cnt    <= '0;
      wr_offset <= '0;
      fmt_req   <= 1'b0;
      disc_req  <= 1'b0;
      stat_req  <= 1'b0;
      invalid_cnt <= '0;
      overrun_cnt <= '0;
    end else begin
      st       <= st_nxt;
      pre      <= ms_tick ? '0 : pre + 1'b1;
      if (ms_tick && ms_cnt < MS_W'(DISC_MS)) ms_cnt <= ms_cnt + 1'b1;
      if (pkt_valid) wr_offset <= (st_nxt == S_SECOND) ? HALF : '0;
      fmt_req  <= hit_fmt;
      disc_req <= hit_disc;
      stat_req <= hit_stat;
      if (hit_inv && invalid_cnt != '1) invalid_cnt <= invalid_cnt + 1'b1;
      if (hit_ovr && overrun_cnt != '1) overrun_cnt <= overrun_cnt + 1'b1;
    end
  end

  logic [2:0] lamp_trig, lamp_on;
  assign lamp_trig = {hit_fmt, hit_inv || hit_ovr, pkt_valid};

  for (genvar i = 0; i < 3; i++) begin : g_lamp
    logic [LT_W-1:0] hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold <= '0;
      else if (lamp_trig[i])     hold <= LT_W'(STRETCH_MS);
      else if (ms_tick && hold != '0) hold <= hold - 1'b1;
    end
    assign lamp_on[i] = (hold != '0);
  end

  assign led_comm = lamp_on[0];
  assign led_err  = lamp_on[1];
  assign led_id   = lamp_on[2];

  initial begin
    a_r5_half_len_distinct: assert (HALF_LEN > 4 && HALF_LEN < (1 << LEN_W));
  end

  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'd3);

  a_r6_fmt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_req |-> $past(pkt_valid) && $past(fb_idle) && $past(st) == S_SECOND);

  a_r4_stat_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && is_cmd |=> st == S_IGN);

  a_r8_offset_only_second: assert property (@(posedge clk) disable iff (!rst_n)
    wr_offset != '0 |-> st == S_SECOND);

  a_r2_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fmt_req, disc_req, stat_req}));

  a_r10_inv_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_cnt >= $past(invalid_cnt));

  a_r10_ovr_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_cnt >= $past(overrun_cnt));

  a_r9_comm_lit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> led_comm);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> $stable(st) && $stable(wr_offset));
endmodule

// File: tb/tb_pkt_proto_ctrl.sv
module tb_pkt_proto_ctrl;
  localparam int LEN_W = 8, HALF_LEN = 12, CNT_W = 4;
  localparam int TPM = 4, DISC_MS = 100, STRETCH_MS = 50;
  localparam logic [31:0] ID = 32'hA5C3_1E07;

  logic clk = 0, rst_n = 0, pkt_valid = 0, fb_idle = 1;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [7:0] pkt_byte = '0;
  logic [31:0] pkt_word = '0;
  logic [LEN_W-1:0] wr_offset;
  logic fmt_req, disc_req, stat_req, led_comm, led_err, led_id;
  logic [CNT_W-1:0] invalid_cnt, overrun_cnt;

  pkt_proto_ctrl #(.LEN_W(LEN_W), .HALF_LEN(HALF_LEN), .CNT_W(CNT_W),
    .TICKS_PER_MS(TPM), .DISC_MS(DISC_MS), .STRETCH_MS(STRETCH_MS)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_byte(pkt_byte), .pkt_word(pkt_word), .node_id(ID), .fb_idle(fb_idle),
    .wr_offset(wr_offset), .fmt_req(fmt_req), .disc_req(disc_req),
    .stat_req(stat_req), .invalid_cnt(invalid_cnt), .overrun_cnt(overrun_cnt),
    .led_comm(led_comm), .led_err(led_err), .led_id(led_id));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_st = 2;
  int m_inv = 0, m_ovr = 0;
  bit early = 1;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > (1 << CNT_W) - 1) ? (1 << CNT_W) - 1 : v;
  endfunction

  task automatic send(int len, logic [31:0] word, logic [7:0] b, bit idle);
    bit e_fmt = 0, e_disc = 0, e_stat = 0;
    int e_off;
    if (len == 0) e_disc = early;
    else if (len == 4) m_st = (word == ID) ? 0 : 2;
    else if (len == 1) begin
      if (m_st == 0) e_stat = (b == 8'h01); else m_inv = sat(m_inv + 1);
      m_st = 2;
    end else if (len == HALF_LEN) begin
      if (m_st == 0) m_st = 1;
      else if (m_st == 1) begin
        if (idle) e_fmt = 1; else m_ovr = sat(m_ovr + 1);
        m_st = 2;
      end
    end else begin
      m_inv = sat(m_inv + 1);
      m_st = 2;
    end
    e_off = (m_st == 1) ? HALF_LEN : 0;
    pkt_valid = 1; pkt_len = LEN_W'(len); pkt_word = word; pkt_byte = b; fb_idle = idle;
    @(negedge clk);
    pkt_valid = 0;
    chk("R6 fmt_req", 32'(fmt_req), 32'(e_fmt));
    chk("R2 disc_req", 32'(disc_req), 32'(e_disc));
    chk("R4 stat_req", 32'(stat_req), 32'(e_stat));
    chk("R8 wr_offset", 32'(wr_offset), 32'(e_off));
    chk("R7 invalid_cnt", 32'(invalid_cnt), 32'(m_inv));
    chk("R6 overrun_cnt", 32'(overrun_cnt), 32'(m_ovr));
    chk("R9 led_comm", 32'(led_comm), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_offset", 32'(wr_offset), 0);
    chk("R1 pulses", 32'({fmt_req, disc_req, stat_req}), 0);
    chk("R1 counters", 32'({invalid_cnt, overrun_cnt}), 0);
    chk("R1 lamps", 32'({led_comm, led_err, led_id}), 0);
    // R1: ignore state -> 1-byte packet is invalid
    send(1, 0, 8'h01, 1);
    // R2 discovery inside window
    send(0, 0, 0, 1);
    // R3 R5 R6 accepted image
    send(4, ID, 0, 1);
    send(HALF_LEN, 0, 0, 1);
    send(HALF_LEN, 0, 0, 1);
    chk("R6 led_id", 32'(led_id), 1);
    // R5 half packet while ignoring
    send(HALF_LEN, 0, 0, 1);
    // R3 wrong address, then status attempt counts as invalid
    send(4, ID ^ 32'h1, 0, 1);
    send(1, 0, 8'h01, 1);
    // R4 status and other command
    send(4, ID, 0, 1); send(1, 0, 8'h01, 1);
    send(4, ID, 0, 1); send(1, 0, 8'h07, 1);
    // R6 overrun
    send(4, ID, 0, 1); send(HALF_LEN, 0, 0, 1); send(HALF_LEN, 0, 0, 0);
    // R9 lamps go dark after hold time
    repeat (STRETCH_MS * TPM + 10) @(negedge clk);
    chk("R9 comm dark", 32'(led_comm), 0);
    chk("R9 id dark", 32'(led_id), 0);
    chk("R9 err dark", 32'(led_err), 0);
    // R2 outside window
    repeat (DISC_MS * TPM) @(negedge clk);
    early = 0;
    send(0, 0, 0, 1);
    // R9 retrigger keeps error lamp lit
    for (int k = 0; k < 4; k++) begin
      send(7, 0, 0, 1);
      repeat ((STRETCH_MS - 2) * TPM) @(negedge clk);
      chk("R9 err held", 32'(led_err), 1);
    end
    repeat (STRETCH_MS * TPM + 10) @(negedge clk);
    chk("R9 err released", 32'(led_err), 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      int len;
      logic [31:0] w;
      case (sel)
        0: len = 0;
        1, 2: len = 1;
        3, 4, 5: len = 4;
        6, 7, 8: len = HALF_LEN;
        default: len = $urandom_range(2, 60);
      endcase
      w = $urandom_range(0, 1) ? ID : $urandom;
      send(len, w, 8'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    // R10 saturation
    for (int i = 0; i < 20; i++) send(3, 0, 0, 1);
    chk("R10 invalid saturated", 32'(invalid_cnt), (1 << CNT_W) - 1);
    for (int i = 0; i < 20; i++) begin
      send(4, ID, 0, 1); send(HALF_LEN, 0, 0, 1); send(HALF_LEN, 0, 0, 0);
    end
    chk("R10 overrun saturated", 32'(overrun_cnt), (1 << CNT_W) - 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule